// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture channel. It takes a raw external input, brings it into the clock domain, and looks for edges of a chosen kind. When an edge event qualifies under the programmed mode, the block copies the current value of one of two 16-bit free-running timers into a small first-in first-out store. Host logic drains the store one word at a time.

Some modes act on every edge. Other modes count rising edges and capture only on every 4th or every 16th one. A sticky interrupt flag rises once a programmed number of captures has taken place. A separate mode raises the flag on any edge without storing anything, so the input can serve as a wake-up source.

Top module: `icap_channel`

## Requirements
- R1: Each capture stores the full 16-bit value of `tmr_a` when `tbase_sel` is 0, or of `tmr_b` when it is 1, sampled in the cycle the capture is accepted.
- R2: Mode code 3'b001 captures on both edges of the input, 3'b010 on falling edges only, and 3'b011 on rising edges only.
- R3: Mode code 3'b100 captures on every 4th rising edge and 3'b101 on every 16th rising edge, counted from entry into the mode.
- R4: Any change of the mode code restarts the rising-edge count, so edges seen before the change do not count toward the next prescaled capture.
- R5: The store holds 4 words and returns them oldest first. `cap_data` shows the oldest word while `cap_valid` is 1, and a one-cycle `cap_pop` removes it.
- R6: A capture that finds the store full is dropped and sets `cap_ovf`. `cap_ovf` stays set until the next word is removed.
- R7: The flag sets once (`irq_every` + 1) capture events have occurred since the last time it was set or the last mode-000 period. Dropped captures count as events.
- R8: `irq_flag` stays set until `irq_clr` is asserted. If a set and a clear fall in the same cycle, the set wins.
- R9: Mode code 3'b111 sets the flag on any edge and stores nothing. Mode code 3'b110 neither stores nor flags.
- R10: Mode code 3'b000 empties the store and clears `cap_ovf`, the edge prescaler and the event tally. It leaves `irq_flag` unchanged.
- R11: After reset the store is empty, and `cap_ovf` and `irq_flag` are 0.
- R12: The input passes through a two-stage synchronizer. An edge at `pin` changes `cap_valid` 3 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin | input | 1 | Raw external capture input |
| tmr_a | input | 16 | Timer base 0 value |
| tmr_b | input | 16 | Timer base 1 value |
| mode | input | 3 | Capture mode code |
| tbase_sel | input | 1 | Time-base select |
| irq_every | input | 2 | Captures per interrupt, minus one |
| cap_pop | input | 1 | Remove the oldest stored word |
| cap_data | output | 16 | Oldest stored word |
| cap_valid | output | 1 | Store not empty |
| cap_ovf | output | 1 | Sticky capture-dropped status |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clear the interrupt flag |

## Verification
A prescaler that is out of step shows up as a missing capture or an extra one. This appears at `cap_valid` on the qualifying rising edge, which can be up to 16 edges after the fault. A tally that is off by one moves the rise of `irq_flag` by a whole capture. A read or write pointer fault returns stale or reordered words at `cap_data`, and this shows on the very next pop. For that reason the tests drain the store completely and compare every word, and they count captures against the expected number instead of checking only for presence.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int TMR_W = 16;

    typedef enum logic [2:0] {
        MD_OFF    = 3'b000,
        MD_BOTH   = 3'b001,
        MD_FALL   = 3'b010,
        MD_RISE   = 3'b011,
        MD_DIV4   = 3'b100,
        MD_DIV16  = 3'b101,
        MD_RSVD   = 3'b110,
        MD_WAKE   = 3'b111
    } icap_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_s;

    function automatic logic is_div_mode(icap_mode_e m);
        return (m == MD_DIV4) || (m == MD_DIV16);
    endfunction

    function automatic logic is_capture_mode(icap_mode_e m);
        return (m == MD_BOTH) || (m == MD_FALL) || (m == MD_RISE) || is_div_mode(m);
    endfunction

endpackage

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
#(
    parameter int SYNC_LEN = 2,
    parameter int PS_W     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  icap_mode_e mode,
    output logic       cap_evt,
    output logic       wake_evt,
    output logic       flush
);
    localparam logic [PS_W-1:0] LAST_DIV4  = 3;
    localparam logic [PS_W-1:0] LAST_DIV16 = 15;

    logic [SYNC_LEN:0] chain;
    edge_s             edg;
    icap_mode_e        mode_q;
    logic [PS_W-1:0]   pcnt;
    logic              restart;
    logic              ps_hit;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_LEN-1:0], pin};
    end

    always_comb begin
        edg.rise = chain[SYNC_LEN-1] & ~chain[SYNC_LEN];
        edg.fall = ~chain[SYNC_LEN-1] & chain[SYNC_LEN];
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_OFF;
        else     mode_q <= mode;
    end

    assign restart = (mode != mode_q) || (mode == MD_OFF);
    assign flush   = (mode == MD_OFF);

    always_comb begin
        case (mode)
            MD_DIV4:  ps_hit = (pcnt == LAST_DIV4);
            MD_DIV16: ps_hit = (pcnt == LAST_DIV16);
            default:  ps_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart)                   pcnt <= '0;
        else if (edg.rise && is_div_mode(mode)) pcnt <= ps_hit ? '0 : pcnt + 1'b1;
    end

    always_comb begin
        case (mode)
            MD_BOTH:          cap_evt = edg.rise | edg.fall;
            MD_FALL:          cap_evt = edg.fall;
            MD_RISE:          cap_evt = edg.rise;
            MD_DIV4, MD_DIV16: cap_evt = edg.rise & ps_hit & ~restart;
            default:          cap_evt = 1'b0;
        endcase
    end

    assign wake_evt = (mode == MD_WAKE) && (edg.rise || edg.fall);

    // R3: the divide-by-4 count never passes its terminal value
    a_r3_div4_range: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_DIV4 && mode_q == MD_DIV4) |-> (pcnt <= LAST_DIV4));

    // R4: a mode change leaves the prescaler at zero
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> (pcnt == '0));

    // R9: no capture outside the capture modes
    a_r9_no_cap: assert property (@(posedge clk) disable iff (rst)
        !is_capture_mode(mode) |-> !cap_evt);

endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)         ovf <= 1'b0;
        else if (do_pop)          ovf <= 1'b0;
        else if (push && full)    ovf <= 1'b1;
    end

    assign rdata     = mem[rd_ptr];
    assign not_empty = (count != '0);

    // R5: occupancy bounded by depth
    a_r5_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R6: overflow only rises after a push into a full store
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(push && full));

    // R10: a flush leaves the store empty and the overflow clear
    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!not_empty && !ovf));

endmodule

// File: rtl/icap_irq.sv
module icap_irq #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             cap_evt,
    input  logic             wake_evt,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] tally;
    logic             hit, set;

    assign hit = cap_evt && (tally >= thresh);
    assign set = hit || wake_evt;

    always_ff @(posedge clk) begin
        if (rst || flush)  tally <= '0;
        else if (cap_evt)  tally <= hit ? '0 : tally + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R8: a lone clear drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R8: without a clear the flag holds
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R7: a set request always shows on the flag
    a_r7_set: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SYNC_LEN = 2,
    parameter int PS_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  logic [TMR_W-1:0] tmr_a,
    input  logic [TMR_W-1:0] tmr_b,
    input  logic [2:0]       mode,
    input  logic             tbase_sel,
    input  logic [1:0]       irq_every,
    input  logic             cap_pop,
    output logic [TMR_W-1:0] cap_data,
    output logic             cap_valid,
    output logic             cap_ovf,
    output logic             irq_flag,
    input  logic             irq_clr
);
    icap_mode_e       mode_e;
    logic             cap_evt, wake_evt, flush;
    logic [TMR_W-1:0] tbase;

    assign mode_e = icap_mode_e'(mode);
    assign tbase  = tbase_sel ? tmr_b : tmr_a;

    icap_edge #(.SYNC_LEN(SYNC_LEN), .PS_W(PS_W)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (pin),
        .mode     (mode_e),
        .cap_evt  (cap_evt),
        .wake_evt (wake_evt),
        .flush    (flush)
    );

    icap_fifo #(.W(TMR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (cap_evt),
        .wdata     (tbase),
        .pop       (cap_pop),
        .rdata     (cap_data),
        .not_empty (cap_valid),
        .ovf       (cap_ovf)
    );

    icap_irq #(.CNT_W(2)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .cap_evt  (cap_evt),
        .wake_evt (wake_evt),
        .thresh   (irq_every),
        .clr      (irq_clr),
        .flag     (irq_flag)
    );

    // R11: quiet outputs right after reset
    a_r11_reset: assert property (@(posedge clk)
        $past(rst) |-> (!cap_valid && !cap_ovf && !irq_flag));

    // R9: wake mode never fills the store
    a_r9_wake_nostore: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MD_WAKE && !cap_valid) |=> !cap_valid);

endmodule

// File: tb/test_icap_channel.sv
`timescale 1ns/1ps
module test_icap_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b0;
    logic [15:0] tmr_a = 16'h0, tmr_b = 16'h0;
    logic [2:0]  mode = 3'b000;
    logic        tbase_sel = 1'b0;
    logic [1:0]  irq_every = 2'd0;
    logic        cap_pop = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] cap_data;
    logic        cap_valid, cap_ovf, irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    icap_channel i_icap_channel (
        .clk(clk), .rst(rst), .pin(pin), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .mode(mode), .tbase_sel(tbase_sel), .irq_every(irq_every),
        .cap_pop(cap_pop), .cap_data(cap_data), .cap_valid(cap_valid),
        .cap_ovf(cap_ovf), .irq_flag(irq_flag), .irq_clr(irq_clr)
    );

    // fields: mode(3) tsel(1) every(2) pulses(5) words(3) flag(1) ovf(1)
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        {3'd1, 1'b0, 2'd0, 5'd1,  3'd2, 1'b1, 1'b0},  // R2 both edges
        {3'd2, 1'b1, 2'd3, 5'd3,  3'd3, 1'b0, 1'b0},  // R2 falling, R7 below count
        {3'd3, 1'b0, 2'd3, 5'd4,  3'd4, 1'b1, 1'b0},  // R2 rising, R7 at 4
        {3'd3, 1'b1, 2'd1, 5'd6,  3'd4, 1'b1, 1'b1},  // R6 overflow
        {3'd4, 1'b0, 2'd0, 5'd7,  3'd1, 1'b1, 1'b0},  // R3 every 4th
        {3'd4, 1'b1, 2'd1, 5'd7,  3'd1, 1'b0, 1'b0},  // R3, R7
        {3'd5, 1'b0, 2'd0, 5'd15, 3'd0, 1'b0, 1'b0},  // R3 every 16th, short
        {3'd5, 1'b1, 2'd0, 5'd16, 3'd1, 1'b1, 1'b0},  // R3 every 16th
        {3'd7, 1'b0, 2'd0, 5'd1,  3'd0, 1'b1, 1'b0},  // R9 wake
        {3'd6, 1'b0, 2'd0, 5'd1,  3'd0, 1'b0, 1'b0},  // R9 reserved
        {3'd2, 1'b0, 2'd2, 5'd2,  3'd2, 1'b0, 1'b0}   // R2, R7
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin = 1'b1; cyc(3);
            pin = 1'b0; cyc(3);
        end
        cyc(4);
    endtask

    task automatic go_off();
        mode = 3'b000; irq_clr = 1'b1; cyc(1);
        irq_clr = 1'b0; cyc(2);
    endtask

    task automatic drain(input logic [15:0] expv, output int n);
        n = 0;
        while (cap_valid && n < 8) begin
            chk(cap_data == expv, "R1/R5 word", cap_data, expv);
            cap_pop = 1'b1; cyc(1);
            cap_pop = 1'b0;
            n++;
        end
    endtask

    initial begin : main
        int nw;
        logic [15:0] ev;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(!cap_valid, "R11 empty", cap_valid, 0);
        chk(!cap_ovf, "R11 ovf", cap_ovf, 0);
        chk(!irq_flag, "R11 flag", irq_flag, 0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] e;
            e = VEC[v];
            go_off();
            tmr_a = 16'hA000 + 16'(v);
            tmr_b = 16'hB000 + 16'(v);
            tbase_sel = e[12];
            irq_every = e[11:10];
            mode = e[15:13];
            cyc(4);
            pulses(int'(e[9:5]));
            chk(cap_ovf == e[0], "R6 ovf", cap_ovf, e[0]);
            chk(irq_flag == e[1], "R7/R9 flag", irq_flag, e[1]);
            ev = e[12] ? tmr_b : tmr_a;
            drain(ev, nw);
            chk(nw == int'(e[4:2]), "R2/R3/R5 count", nw, e[4:2]);
            chk(!cap_ovf, "R6 ovf cleared by pop", cap_ovf, 0);
        end

        // R12 latency: edge reaches cap_valid on the third clock edge
        go_off();
        tbase_sel = 1'b0; mode = 3'b011; cyc(4);
        pin = 1'b1; cyc(2);
        chk(!cap_valid, "R12 not yet", cap_valid, 0);
        cyc(1);
        chk(cap_valid, "R12 captured", cap_valid, 1);
        pin = 1'b0; cyc(4);

        // R8 sticky flag and clear
        go_off();
        irq_every = 2'd0; mode = 3'b011; cyc(4);
        pulses(1);
        cyc(10);
        chk(irq_flag, "R8 flag held", irq_flag, 1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk(!irq_flag, "R8 flag cleared", irq_flag, 0);

        // R10 off mode flushes but keeps flag
        pulses(5);
        chk(cap_ovf, "R10 ovf before off", cap_ovf, 1);
        mode = 3'b000; cyc(2);
        chk(!cap_valid && !cap_ovf, "R10 flushed", {cap_valid, cap_ovf}, 0);
        chk(irq_flag, "R10 flag kept", irq_flag, 1);

        // R4 mode change restarts the prescaler
        go_off();
        mode = 3'b100; cyc(4);
        pulses(3);
        mode = 3'b101; cyc(3);
        mode = 3'b100; cyc(4);
        pulses(3);
        chk(!cap_valid, "R4 no early capture", cap_valid, 0);
        pulses(1);
        chk(cap_valid, "R4 capture on 4th", cap_valid, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule